// File: doc/BRIEF.md
# Indexed block-transfer register slave for a two-wire management bus

The block is a target on an SMBus-style two-wire bus. It gives a host read and write access to a small file of byte-wide configuration registers, and it drives the whole file onto a flat output vector for the rest of the chip. It samples SCL and SDA with a fast system clock through two-flop synchronizers. It recognises start, repeated-start and stop conditions from SDA edges that occur while SCL is high. It pulls SDA low through an open-drain output enable.

Every transaction opens with the write-direction address and a starting register index. On a write, the host then sends a byte count and that many data bytes. On a read, the host issues a repeated start and the read-direction address. The slave answers with a count byte, taken from a fixed register, and then sends register contents from the index onward. The index advances after every data byte and wraps at the end of the file. Clock stretching, packet error codes, bus timeouts and alert signalling are not part of the block.

Top module: `smb_cfg_slave`

## Requirements
- R1: An address byte of 0xD0 (7-bit address 0x68 with bit 0 = 0, write) or 0xD1 (bit 0 = 1, read) is acknowledged: SDA is held low during the ninth clock.
- R2: Any other address byte (for example 0xA0 or 0xD2) is not acknowledged. The slave then leaves SDA released, does not acknowledge later bytes and changes no register until the next start.
- R3: In a write, the byte after the address is the starting index N, with only its low 5 bits used. The next byte is the count X. The following X data bytes are stored in registers N, N+1 and onward. The index byte, the count byte and every data byte are acknowledged.
- R4: After a repeated start and the read address, the slave first sends the value of register 8 as the count byte and then sends the registers from index N onward, each most significant bit first.
- R5: The 32-entry index wraps from 31 to 0 when it advances, in both writes and reads.
- R6: In a read, the slave keeps sending the next register for as long as the host acknowledges, including past the reported count. After a not-acknowledge it releases SDA and sends nothing more until the next start.
- R7: A stop or a start that arrives in the middle of a byte ends the transfer. Registers completed before it keep their values, and the partial byte is never stored.
- R8: After reset, SDA is released and all registers read 0.
- R9: The slave changes its SDA drive only while SCL is low, so it never creates a start or stop condition itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | 256 | Register file contents, register k at bits 8k+7:8k |

## Verification
The assertions check four properties on every cycle: the SDA drive changes only while the synchronized SCL is low, register contents change only while SCL is low, SDA is released in the idle state, and a detected stop releases SDA on the next cycle. Only the bench scenarios can show byte-level behaviour. That covers the acknowledge pattern for matching and foreign addresses, the count byte coming from register 8, index wrap, reads that run past the count, and the effect of a stop or start arriving in the middle of a byte on the stored values.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_HACK
  } smb_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_IDX,
    K_CNT,
    K_DATA
  } smb_kind_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw;
  logic [1:0] synced;
  logic [1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= '1;
      else         pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign synced[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= '1;
    else         prev <= synced;
  end

  assign scl_o      = synced[1];
  assign sda_o      = synced[0];
  assign scl_rise_o = synced[1] & ~prev[1];
  assign scl_fall_o = ~synced[1] & prev[1];
  // SDA edge while SCL stays high
  assign start_o    = synced[1] & prev[1] & prev[0] & ~synced[0];
  assign stop_o     = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int NUM_REGS = 32,
  parameter int CNT_IDX  = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [7:0]            rd_data_o,
  output logic [7:0]            cnt_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))    mem[g] <= wr_data_i;
    end
    assign regs_o[g*8 +: 8] = mem[g];
  end

  assign rd_data_o = mem[rd_idx_i];
  assign cnt_o     = mem[CNT_IDX];
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int NUM_REGS = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  input  logic [7:0]       cnt_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o,
  output smb_state_e       state_o
);
  smb_state_e state;
  smb_kind_e  kind;
  logic [3:0]       bit_cnt;
  logic [7:0]       rx_sh;
  logic [7:0]       tx_sh;
  logic [IDX_W-1:0] idx;
  logic             rd_dir;
  logic             host_ack;
  logic             byte_done;
  logic [IDX_W-1:0] idx_nxt;

  assign idx_nxt   = (idx == IDX_W'(NUM_REGS - 1)) ? '0 : idx + 1'b1;
  assign byte_done = (state == ST_RX) && scl_fall_i && (bit_cnt == 4'd8);
  assign wr_en_o   = byte_done && (kind == K_DATA);
  assign wr_data_o = rx_sh;
  assign idx_o     = idx;
  assign state_o   = state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      idx      <= '0;
      rd_dir   <= 1'b0;
      host_ack <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (start_i) begin
      state    <= ST_RX;
      kind     <= K_ADDR;
      bit_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_i) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise_i && bit_cnt != 4'd8) begin
            rx_sh   <= {rx_sh[6:0], sda_s_i};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            state    <= ST_ACK;
            sda_oe_o <= 1'b1;
            unique case (kind)
              K_ADDR: begin
                rd_dir <= rx_sh[0];
                if (rx_sh[7:1] != DEV_ADDR) begin
                  state    <= ST_IDLE;
                  sda_oe_o <= 1'b0;
                end
              end
              K_IDX:   idx <= rx_sh[IDX_W-1:0];
              K_CNT:   ;
              default: idx <= idx_nxt;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            bit_cnt <= '0;
            if (kind == K_ADDR && rd_dir) begin
              state    <= ST_TX;
              tx_sh    <= cnt_i;
              sda_oe_o <= ~cnt_i[7];
            end else begin
              state    <= ST_RX;
              sda_oe_o <= 1'b0;
              unique case (kind)
                K_ADDR:  kind <= K_IDX;
                K_IDX:   kind <= K_CNT;
                default: kind <= K_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (bit_cnt == 4'd7) begin
              state    <= ST_HACK;
              sda_oe_o <= 1'b0;
            end else begin
              tx_sh    <= {tx_sh[6:0], 1'b0};
              sda_oe_o <= ~tx_sh[6];
              bit_cnt  <= bit_cnt + 1'b1;
            end
          end
        end
        ST_HACK: begin
          if (scl_rise_i) begin
            host_ack <= ~sda_s_i;
          end else if (scl_fall_i) begin
            if (host_ack) begin
              state    <= ST_TX;
              tx_sh    <= rd_data_i;
              sda_oe_o <= ~rd_data_i[7];
              idx      <= idx_nxt;
              bit_cnt  <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int NUM_REGS = 32,
  parameter int CNT_IDX  = 8,
  parameter int STAGES   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic             scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic             wr_en;
  logic [IDX_W-1:0] idx;
  logic [7:0]       wr_data, rd_data, cnt;
  smb_state_e       state;

  smb_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  smb_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_ctrl (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .rd_data_i(rd_data), .cnt_i(cnt),
    .wr_en_o(wr_en), .idx_o(idx), .wr_data_o(wr_data), .sda_oe_o, .state_o(state)
  );

  smb_regfile #(.NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(idx), .wr_data_i(wr_data),
    .rd_idx_i(idx), .rd_data_o(rd_data), .cnt_o(cnt), .regs_o
  );
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
  import smb_pkg::*;
#(
  parameter int W = 256
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         scl_s_i,
  input logic         stop_i,
  input smb_state_e   state_i,
  input logic         sda_oe_i,
  input logic [W-1:0] regs_i
);
  always @(posedge clk_i)
    if (!rst_ni) assert_reset_release_R8: assert (!sda_oe_i) else $error("R8 drive in reset");

  assert_oe_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_s_i) else $error("R9 drive changed with SCL high");

  assert_regs_scl_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs_i) |-> !scl_s_i) else $error("R7 register update with SCL high");

  assert_idle_released_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IDLE |-> !sda_oe_i) else $error("R2 drive while idle");

  assert_stop_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i) else $error("R6 drive after stop");
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.W(NUM_REGS*8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .stop_i(stop),
  .state_i(state), .sda_oe_i(sda_oe_o), .regs_i(regs_o)
);

// File: tb/smb_cfg_slave_test.sv
module smb_cfg_slave_test;
  localparam int Q = 8;
  localparam int NR = 32;

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_h = 1;
  logic sda_oe;
  logic [NR*8-1:0] regs;
  wire sda_line = sda_h & ~sda_oe;

  int n_chk = 0, n_fail = 0, r9_bad = 0;
  bit done = 0;
  logic [7:0] exp_r [NR];
  logic [7:0] wbuf [8];
  logic prev_scl = 1, prev_oe = 0;

  always #2.5 clk = ~clk;

  smb_cfg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  // R9 monitor: drive must not change while SCL is high
  always @(negedge clk) begin
    if (rst_n && scl && prev_scl && sda_oe != prev_oe) r9_bad++;
    prev_scl <= scl;
    prev_oe  <= sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic host_start();
    sda_h = 1; wq(); scl = 1; wq(); sda_h = 0; wq(); scl = 0; wq();
  endtask

  task automatic host_stop();
    sda_h = 0; wq(); scl = 1; wq(); sda_h = 1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; wq(); scl = 1; wq(); wq(); scl = 0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_h = 1; wq(); scl = 1; wq(); b = sda_line; wq(); scl = 0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(~ack);
  endtask

  task automatic cmp_regs(input string tag);
    int bad = 0;
    for (int i = 0; i < NR; i++) if (regs[i*8 +: 8] !== exp_r[i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic blk_write(input logic [7:0] idx, input int n);
    logic a;
    host_start();
    send_byte(8'hD0, a); chk(a, "R1 write address ack", a, 1);
    send_byte(idx, a);   chk(a, "R3 index ack", a, 1);
    send_byte(8'(n), a); chk(a, "R3 count ack", a, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); chk(a, "R3 data ack", a, 1);
      exp_r[(idx + i) % NR] = wbuf[i];
    end
    host_stop();
    wq();
  endtask

  task automatic blk_read(input logic [7:0] idx, input int n);
    logic a;
    logic [7:0] d;
    host_start();
    send_byte(8'hD0, a);
    send_byte(idx, a);
    sda_h = 1; wq(); scl = 1; wq(); sda_h = 0; wq(); scl = 0; wq();  // repeated start
    send_byte(8'hD1, a); chk(a, "R1 read address ack", a, 1);
    recv_byte(1'b1, d);  chk(d == exp_r[8], "R4 count byte", d, exp_r[8]);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == exp_r[(idx + i) % NR], "R4 R5 R6 read data", d, exp_r[(idx + i) % NR]);
    end
    wq();
    chk(sda_oe == 0, "R6 released after nack", sda_oe, 0);
    host_stop();
    wq();
  endtask

  task automatic t_reset();
    chk(sda_oe == 0, "R8 sda released", sda_oe, 0);
    chk(regs == '0, "R8 regs zero", 0, 0);
  endtask

  task automatic t_write_read();
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
    blk_write(8'd4, 3);
    cmp_regs("R3 stored block");
    wbuf[0] = 8'h05;
    blk_write(8'd8, 1);
    blk_read(8'd4, 5);
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'h11; wbuf[1] = 8'hE2; wbuf[2] = 8'h93; wbuf[3] = 8'h7F;
    blk_write(8'd30, 4);
    cmp_regs("R5 write wraps 31 to 0");
    // count is 5, read 7 bytes: past the count and across the wrap
    blk_read(8'd30, 7);
  endtask

  task automatic t_bad_addr();
    logic a;
    host_start();
    send_byte(8'hA0, a); chk(!a, "R2 foreign address nack", a, 0);
    send_byte(8'h02, a); chk(!a, "R2 later byte nack", a, 0);
    send_byte(8'h55, a);
    host_stop();
    host_start();
    send_byte(8'hD2, a); chk(!a, "R2 address 0xD2 nack", a, 0);
    host_stop();
    wq();
    cmp_regs("R2 regs unchanged");
  endtask

  task automatic t_abort();
    logic a;
    host_start();
    send_byte(8'hD0, a); send_byte(8'd10, a); send_byte(8'd2, a);
    send_byte(8'h77, a); exp_r[10] = 8'h77;
    send_bit(1); send_bit(1); send_bit(0); send_bit(1);
    host_stop();
    wq();
    cmp_regs("R7 stop mid-byte keeps completed data");
    host_start();
    send_byte(8'hD0, a); send_byte(8'd12, a); send_byte(8'd1, a);
    send_bit(1); send_bit(0); send_bit(1);
    host_start();  // start mid-byte
    send_byte(8'hD0, a); chk(a, "R7 address ack after restart", a, 1);
    send_byte(8'd12, a); send_byte(8'd1, a); send_byte(8'h3C, a);
    exp_r[12] = 8'h3C;
    host_stop();
    wq();
    cmp_regs("R7 start mid-byte then clean write");
  endtask

  initial begin
    for (int i = 0; i < NR; i++) exp_r[i] = '0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_write_read();
    t_wrap();
    t_bad_addr();
    t_abort();
    chk(r9_bad == 0, "R9 drive stable while SCL high", r9_bad, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule